// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 26-bit logical address into a 24-bit physical address. There is no translation cache. A four-slot segment register file supplies the base of the first table for each segment. The walker then fetches one 4-byte entry from each of three table levels over a request/response memory port. Each table fits in a single 256-byte page. The first level is indexed by 4 bits of the page number and the next two levels by 6 bits each. An entry whose valid bit is clear stops the walk and reports a fault that names the failing level.

The walker is a five-state machine. Its states are IDLE, OUTER, MIDDLE, INNER and DONE, with these transitions:

- IDLE goes to OUTER when a request arrives.
- OUTER goes to MIDDLE when a valid response arrives.
- MIDDLE goes to INNER when a valid response arrives.
- INNER goes to DONE when a valid response arrives.
- OUTER, MIDDLE and INNER each go to DONE when an invalid response arrives.
- DONE always goes back to IDLE.

In each table state, the block issues one read and then waits for its response. DONE shows the result for exactly one cycle.

The segment slots are loaded through a one-cycle write strobe. A walk latches its segment base in the cycle it is accepted, so later writes to the slots do not disturb a walk already in progress.

Top module: `ptw_top`

## Requirements
- R1: After reset the block is in IDLE: `req_ready` is 1, and `mem_req_valid` and `done` are 0.
- R2: A cycle with `seg_we` high stores `seg_wbase` in slot `seg_widx`. Every later walk for that segment reads its first entry relative to that base.
- R3: The logical address splits as follows:
  - bits 25:24 select the segment;
  - bits 23:20 index the outer table;
  - bits 19:14 index the middle table;
  - bits 13:8 index the inner table;
  - bits 7:0 are the byte offset.
- R4: Each entry address is the table base plus four times the index, modulo 2^24. The base of the middle and inner tables is the previous entry's frame number followed by eight zero bits.
- R5: Reads go out one at a time. `mem_req_valid` is a one-cycle pulse per level, and no new pulse appears until the previous read has received its `mem_rsp_valid`.
- R6: In a table entry, bit 31 is the valid flag and bits 15:0 are the frame number. Bits 30:16 have no effect on the result.
- R7: A walk with three valid entries issues exactly three reads. It ends with a result of `done_fault`=0, `done_level`=0 and `done_paddr` = {third frame number, offset}.
- R8: An invalid entry at level k stops the walk, where k is 1 for outer, 2 for middle and 3 for inner. The walk issues no further read and ends with `done_fault`=1, `done_level`=k and `done_paddr`=0.
- R9: A request is taken only in IDLE. `req_ready` is low during a walk, and `req_valid` during a walk changes neither its reads nor its result.
- R10: A segment write in the same cycle as a request is accepted does not affect that walk, which uses the slot's previous contents.
- R11: `done` is high for exactly one cycle, and `req_ready` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_we | input | 1 | Segment slot write strobe |
| seg_widx | input | 2 | Segment slot to write |
| seg_wbase | input | 24 | Outer-table base for that slot |
| req_valid | input | 1 | Translation request |
| req_laddr | input | 26 | Logical address to translate |
| req_ready | output | 1 | Walker idle, request taken this cycle if valid |
| mem_req_valid | output | 1 | One-cycle read request |
| mem_req_addr | output | 24 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | Result present for one cycle |
| done_paddr | output | 24 | Physical address (0 on fault) |
| done_fault | output | 1 | Walk hit an invalid entry |
| done_level | output | 2 | Failing level 1..3, or 0 on success |

## Verification
Two functions can meet in a single cycle: a segment slot write and the acceptance of a request for that same segment. The bench provokes this by raising `seg_we` and `req_valid` on the same edge with a new base. It judges the outcome from the first read address, which must be built from the old base. The bench also raises `req_valid` in the middle of a walk and judges that the read sequence and the result still match the original address. Random walks mix memory latencies of one to three cycles with random values in the ignored entry bits.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int SEG_W      = 2;
    localparam int L1_W       = 4;
    localparam int L2_W       = 6;
    localparam int L3_W       = 6;
    localparam int OFF_W      = 8;
    localparam int FRAME_W    = 16;
    localparam int PTE_W      = 32;
    localparam int VALID_POS  = 31;
    localparam int ENTRY_BYTES = 4;

    localparam int VPN_W     = L1_W + L2_W + L3_W;
    localparam int LA_W      = SEG_W + VPN_W + OFF_W;
    localparam int PA_W      = FRAME_W + OFF_W;
    localparam int SEG_N     = 1 << SEG_W;
    localparam int ENT_SHIFT = $clog2(ENTRY_BYTES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OUTER,
        ST_MIDDLE,
        ST_INNER,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        LV_NONE   = 2'd0,
        LV_OUTER  = 2'd1,
        LV_MIDDLE = 2'd2,
        LV_INNER  = 2'd3
    } walk_level_e;
endpackage

// File: rtl/ptw_seg_table.sv
module ptw_seg_table import ptw_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEG_W-1:0] widx,
    input  logic [PA_W-1:0]  wdata,
    input  logic [SEG_W-1:0] ridx,
    output logic [PA_W-1:0]  rdata
);
    logic [PA_W-1:0] slot_q [SEG_N];

    for (genvar g = 0; g < SEG_N; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (we && (widx == SEG_W'(g))) begin
                slot_q[g] <= wdata;
            end
        end
    end

    // read of the registered value: a same-cycle write is not visible
    assign rdata = slot_q[ridx];
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr import ptw_pkg::*; (
    input  walk_level_e      level,
    input  logic [VPN_W-1:0] vpn,
    input  logic [PA_W-1:0]  table_base,
    output logic [PA_W-1:0]  entry_addr
);
    logic [PA_W-1:0] idx_ext;

    always_comb begin
        unique case (level)
            LV_OUTER:  idx_ext = PA_W'(vpn[VPN_W-1 -: L1_W]);
            LV_MIDDLE: idx_ext = PA_W'(vpn[L2_W+L3_W-1 -: L2_W]);
            LV_INNER:  idx_ext = PA_W'(vpn[L3_W-1:0]);
            default:   idx_ext = '0;
        endcase
    end

    assign entry_addr = table_base + (idx_ext << ENT_SHIFT);
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode import ptw_pkg::*; (
    input  logic [PTE_W-1:0]   pte,
    output logic               valid,
    output logic [FRAME_W-1:0] frame,
    output logic [PA_W-1:0]    next_base
);
    assign valid     = pte[VALID_POS];
    assign frame     = pte[FRAME_W-1:0];
    assign next_base = {frame, {OFF_W{1'b0}}};
endmodule

// File: rtl/ptw_top.sv
module ptw_top import ptw_pkg::*; (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 seg_we,
    input  logic [SEG_W-1:0]     seg_widx,
    input  logic [PA_W-1:0]      seg_wbase,
    input  logic                 req_valid,
    input  logic [LA_W-1:0]      req_laddr,
    output logic                 req_ready,
    output logic                 mem_req_valid,
    output logic [PA_W-1:0]      mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [PTE_W-1:0]     mem_rsp_data,
    output logic                 done,
    output logic [PA_W-1:0]      done_paddr,
    output logic                 done_fault,
    output logic [1:0]           done_level
);
    walk_state_e      state_q, state_d;
    logic             pending_q;
    logic [PA_W-1:0]  base_q;
    logic [VPN_W-1:0] vpn_q;
    logic [OFF_W-1:0] off_q;
    logic [PA_W-1:0]  paddr_q;
    logic             fault_q;
    walk_level_e      flvl_q;

    logic [PA_W-1:0]    seg_base;
    logic [PA_W-1:0]    ent_addr;
    logic               pte_valid;
    logic [FRAME_W-1:0] pte_frame;
    logic [PA_W-1:0]    pte_next;
    walk_level_e        cur_level;
    logic               walking;
    logic               rsp_take;

    ptw_seg_table u_seg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (seg_we),
        .widx  (seg_widx),
        .wdata (seg_wbase),
        .ridx  (req_laddr[LA_W-1 -: SEG_W]),
        .rdata (seg_base)
    );

    ptw_entry_addr u_addr (
        .level      (cur_level),
        .vpn        (vpn_q),
        .table_base (base_q),
        .entry_addr (ent_addr)
    );

    ptw_pte_decode u_dec (
        .pte       (mem_rsp_data),
        .valid     (pte_valid),
        .frame     (pte_frame),
        .next_base (pte_next)
    );

    always_comb begin
        unique case (state_q)
            ST_OUTER:  cur_level = LV_OUTER;
            ST_MIDDLE: cur_level = LV_MIDDLE;
            ST_INNER:  cur_level = LV_INNER;
            default:   cur_level = LV_NONE;
        endcase
    end

    assign walking  = (state_q == ST_OUTER) || (state_q == ST_MIDDLE) ||
                      (state_q == ST_INNER);
    assign rsp_take = walking && pending_q && mem_rsp_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_OUTER;
            ST_OUTER:  if (rsp_take)  state_d = pte_valid ? ST_MIDDLE : ST_DONE;
            ST_MIDDLE: if (rsp_take)  state_d = pte_valid ? ST_INNER  : ST_DONE;
            ST_INNER:  if (rsp_take)  state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pending_q <= 1'b0;
            base_q    <= '0;
            vpn_q     <= '0;
            off_q     <= '0;
            paddr_q   <= '0;
            fault_q   <= 1'b0;
            flvl_q    <= LV_NONE;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                base_q    <= seg_base;
                vpn_q     <= req_laddr[OFF_W +: VPN_W];
                off_q     <= req_laddr[OFF_W-1:0];
                paddr_q   <= '0;
                fault_q   <= 1'b0;
                flvl_q    <= LV_NONE;
                pending_q <= 1'b0;
            end else if (walking) begin
                if (!pending_q) begin
                    pending_q <= 1'b1;
                end else if (mem_rsp_valid) begin
                    pending_q <= 1'b0;
                    if (!pte_valid) begin
                        fault_q <= 1'b1;
                        flvl_q  <= cur_level;
                    end else if (state_q == ST_INNER) begin
                        paddr_q <= {pte_frame, off_q};
                    end else begin
                        base_q <= pte_next;
                    end
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = walking && !pending_q;
        mem_req_addr  = ent_addr;
        done          = (state_q == ST_DONE);
        done_paddr    = paddr_q;
        done_fault    = fault_q;
        done_level    = flvl_q;
    end
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker import ptw_pkg::*; (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [LA_W-1:0]  req_laddr,
    input logic             req_ready,
    input logic             mem_req_valid,
    input logic             mem_rsp_valid,
    input logic             done,
    input logic [PA_W-1:0]  done_paddr,
    input logic             done_fault,
    input logic [1:0]       done_level
);
    logic             outst_q;
    logic [2:0]       reads_q;
    logic [OFF_W-1:0] off_lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outst_q   <= 1'b0;
            reads_q   <= '0;
            off_lat_q <= '0;
        end else begin
            if (mem_req_valid)      outst_q <= 1'b1;
            else if (mem_rsp_valid) outst_q <= 1'b0;
            if (req_valid && req_ready) begin
                reads_q   <= '0;
                off_lat_q <= req_laddr[OFF_W-1:0];
            end else if (mem_req_valid) begin
                reads_q <= reads_q + 3'd1;
            end
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_ready && !mem_req_valid && !done));

    p_single_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !outst_q);

    p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    p_three_reads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_fault) |-> (reads_q == 3'd3 && done_level == 2'd0));

    p_offset_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_fault) |-> (done_paddr[OFF_W-1:0] == off_lat_q));

    p_fault_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault) |-> (reads_q == {1'b0, done_level} &&
                                  done_level != 2'd0 && done_paddr == '0));

    p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req_valid && !done));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));
endmodule

bind ptw_top ptw_checker u_ptw_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_laddr     (req_laddr),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .done_paddr    (done_paddr),
    .done_fault    (done_fault),
    .done_level    (done_level)
);

// File: tb/ptw_top_bench.sv
`timescale 1ns/1ps
module ptw_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_we = 1'b0;
    logic [1:0]  seg_widx = '0;
    logic [23:0] seg_wbase = '0;
    logic        req_valid = 1'b0;
    logic [25:0] req_laddr = '0;
    logic        req_ready;
    logic        mem_req_valid;
    logic [23:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic [23:0] done_paddr;
    logic        done_fault;
    logic [1:0]  done_level;

    int n_tests = 0;
    int n_fail  = 0;

    logic [23:0] seg_m [4];
    logic [31:0] ent [3];
    logic [23:0] exp_a [3];
    int rd_idx = 0;
    int addr_err = 0;

    always #2 clk = ~clk;

    ptw_top u_ptw_top (
        .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_widx(seg_widx),
        .seg_wbase(seg_wbase), .req_valid(req_valid), .req_laddr(req_laddr),
        .req_ready(req_ready), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .done_paddr(done_paddr),
        .done_fault(done_fault), .done_level(done_level)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] ent_addr(input logic [23:0] base, input int idx);
        return base + 24'(idx * 4);
    endfunction

    function automatic logic [31:0] mk_ent(input bit v, input logic [15:0] fr);
        return {v, 15'($urandom), fr};
    endfunction

    // memory model: one response per request, latency 1..3 cycles
    initial begin
        logic [31:0] d;
        int lat;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_valid) begin
                if (rd_idx > 2 || mem_req_addr !== exp_a[rd_idx]) addr_err++;
                d = ent[(rd_idx < 3) ? rd_idx : 0];
                rd_idx++;
                lat = 1 + int'($urandom % 3);
                repeat (lat) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = d;
            end
        end
    end

    task automatic seg_write(input logic [1:0] idx, input logic [23:0] b);
        @(negedge clk);
        seg_we = 1'b1; seg_widx = idx; seg_wbase = b;
        @(negedge clk);
        seg_we = 1'b0;
        seg_m[idx] = b;
    endtask

    task automatic run_walk(input logic [25:0] la, input logic [31:0] e0,
                            input logic [31:0] e1, input logic [31:0] e2,
                            input bit interfere, input bit same_wr, input string tag);
        logic [1:0]  sg;
        logic [23:0] a0, a1, a2, xpa;
        int x_reads, x_lvl, waitc;
        bit x_fault, seen;
        sg = la[25:24];
        a0 = ent_addr(seg_m[sg], int'(la[23:20]));
        a1 = ent_addr({e0[15:0], 8'h00}, int'(la[19:14]));
        a2 = ent_addr({e1[15:0], 8'h00}, int'(la[13:8]));
        if (!e0[31])      begin x_fault = 1; x_lvl = 1; x_reads = 1; xpa = 0; end
        else if (!e1[31]) begin x_fault = 1; x_lvl = 2; x_reads = 2; xpa = 0; end
        else if (!e2[31]) begin x_fault = 1; x_lvl = 3; x_reads = 3; xpa = 0; end
        else begin x_fault = 0; x_lvl = 0; x_reads = 3; xpa = {e2[15:0], la[7:0]}; end
        ent[0] = e0; ent[1] = e1; ent[2] = e2;
        exp_a[0] = a0; exp_a[1] = a1; exp_a[2] = a2;
        @(negedge clk);
        rd_idx = 0; addr_err = 0;
        chk(req_ready == 1'b1, "R9", {tag, " ready before"}, 32'(req_ready), 1);
        req_valid = 1'b1; req_laddr = la;
        if (same_wr) begin
            seg_we = 1'b1; seg_widx = sg; seg_wbase = seg_m[sg] ^ 24'h5A5A00;
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (same_wr) begin seg_we = 1'b0; seg_m[sg] = seg_wbase; end
        chk(req_ready == 1'b0, "R9", {tag, " busy"}, 32'(req_ready), 0);
        seen = 0;
        for (int c = 0; c < 60; c++) begin
            if (done) begin seen = 1; break; end
            if (interfere && c == 1) begin
                req_valid = 1'b1; req_laddr = ~la;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        waitc = 0;
        chk(seen, "R7", {tag, " done seen"}, 32'(seen), 1);
        chk(done_fault == x_fault, "R8", {tag, " fault"}, 32'(done_fault), 32'(x_fault));
        chk(int'(done_level) == x_lvl, "R8", {tag, " level"}, 32'(done_level), 32'(x_lvl));
        chk(done_paddr == xpa, "R7", {tag, " paddr"}, 32'(done_paddr), 32'(xpa));
        chk(rd_idx == x_reads, "R5", {tag, " read count"}, 32'(rd_idx), 32'(x_reads));
        chk(addr_err == 0, "R4", {tag, " entry addresses"}, 32'(addr_err), 0);
        @(negedge clk);
        chk(done == 1'b0 && req_ready == 1'b1, "R11", {tag, " done pulse"},
            {30'd0, done, req_ready}, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd537));
        for (int i = 0; i < 4; i++) seg_m[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1 && mem_req_valid == 0 && done == 0, "R1", "reset outputs",
            {29'd0, req_ready, mem_req_valid, done}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1 && mem_req_valid == 0 && done == 0, "R1", "after release",
            {29'd0, req_ready, mem_req_valid, done}, 32'h4);

        // R2: load each slot
        seg_write(2'd0, 24'h001000);
        seg_write(2'd1, 24'h0A3400);
        seg_write(2'd2, 24'hFFFFF0);   // wraps for high outer index (R4)
        seg_write(2'd3, 24'h123456);

        // R2 R3 R6 R7: one walk per segment
        run_walk({2'd0, 4'h2, 6'h05, 6'h3F, 8'h70},
                 mk_ent(1, 16'h0011), mk_ent(1, 16'h0022), mk_ent(1, 16'h0003), 0, 0, "R2 seg0");
        run_walk({2'd1, 4'hF, 6'h3F, 6'h00, 8'hFF},
                 mk_ent(1, 16'hFFFF), mk_ent(1, 16'h0000), mk_ent(1, 16'hABCD), 0, 0, "R3 seg1");
        run_walk({2'd2, 4'hF, 6'h01, 6'h02, 8'h16},
                 mk_ent(1, 16'h7777), mk_ent(1, 16'h0102), mk_ent(1, 16'h000B), 0, 0, "R4 wrap");
        run_walk({2'd3, 4'h0, 6'h00, 6'h00, 8'h00},
                 {1'b1, 15'h7FFF, 16'h0042}, {1'b1, 15'h7FFF, 16'h0043},
                 {1'b1, 15'h7FFF, 16'h0044}, 0, 0, "R6 junk bits");

        // R8: fault at each level
        run_walk({2'd0, 4'h1, 6'h02, 6'h03, 8'h44},
                 mk_ent(0, 16'h1234), mk_ent(1, 16'h1), mk_ent(1, 16'h2), 0, 0, "R8 lvl1");
        run_walk({2'd1, 4'h1, 6'h02, 6'h03, 8'h44},
                 mk_ent(1, 16'h0200), mk_ent(0, 16'h1), mk_ent(1, 16'h2), 0, 0, "R8 lvl2");
        run_walk({2'd3, 4'h1, 6'h02, 6'h03, 8'h44},
                 mk_ent(1, 16'h0300), mk_ent(1, 16'h0301), mk_ent(0, 16'h2), 0, 0, "R8 lvl3");

        // R9: request raised mid-walk is ignored
        run_walk({2'd2, 4'h3, 6'h11, 6'h22, 8'h9C},
                 mk_ent(1, 16'h0400), mk_ent(1, 16'h0401), mk_ent(1, 16'h0402), 1, 0, "R9 interfere");

        // R10: slot write in the acceptance cycle, then the new base on the next walk
        run_walk({2'd1, 4'h4, 6'h05, 6'h06, 8'h07},
                 mk_ent(1, 16'h0500), mk_ent(1, 16'h0501), mk_ent(1, 16'h0502), 0, 1, "R10 same cycle");
        run_walk({2'd1, 4'h4, 6'h05, 6'h06, 8'h07},
                 mk_ent(1, 16'h0600), mk_ent(1, 16'h0601), mk_ent(1, 16'h0602), 0, 0, "R10 new base");

        // random walks
        for (int t = 0; t < 60; t++) begin
            logic [25:0] la;
            bit v0, v1, v2;
            la = 26'($urandom);
            v0 = ($urandom % 8) != 0;
            v1 = ($urandom % 8) != 0;
            v2 = ($urandom % 8) != 0;
            if (t % 10 == 0) seg_write(2'($urandom), 24'($urandom));
            run_walk(la, mk_ent(v0, 16'($urandom)), mk_ent(v1, 16'($urandom)),
                     mk_ent(v2, 16'($urandom)), (t % 7) == 3, (t % 9) == 4, "R7 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule